// File: doc/BRIEF.md
# Status Packet Serializer

The block reports a 26-bit status word to an upstream collector as a short byte-serial packet. When a report is due it raises a request and places a fixed status register address on its byte output. The upstream side takes that address byte by pulsing an acknowledge. On the four cycles that follow, the block drives the data bytes with no further handshake. The first data byte carries a 6-bit sequence number above the two lowest status bits. The next three bytes carry the remaining 24 status bits, lowest slice first.

A single control write sets the reporting mode and the sequence number. In single mode, each write produces exactly one packet. In automatic mode, the write produces one packet and every later change of the status word produces another. Off mode withdraws any report that has not yet been taken. The status word, and the sequence number, are captured in the cycle of the acknowledge, so all bytes of one packet describe the same instant. The same control write strobe is also routed outside the block, where it clears sticky flags.

Back-pressure rules: the request is the only point where the upstream side can stall the block. The request stays high for as long as the upstream side needs. Once the acknowledge is given, the data bytes cannot be paused.

Top module: `stat_pkt_ser`

## Requirements
- R1: While the asynchronous reset is high, and after it is released with no write, pkt_rq is 0 and pkt_ad is 0x00.
- R2: Once raised, pkt_rq stays high until pkt_start is sampled high, unless a control write or a reset intervenes; while pkt_rq is high, pkt_ad shows the address 0x21.
- R3: On the four cycles after the cycle in which pkt_start is taken, pkt_ad carries {seq[5:0], status[1:0]}, then status[9:2], then status[17:10], then status[25:18]; after that it returns to 0x00.
- R4: All bytes of a packet come from the status word present in the cycle of the acknowledge; later changes of status_in do not alter the packet in flight.
- R5: A control write loads seq from cfg_wd[7:2] and the mode from cfg_wd[1:0]; code 1, and the reserved code 3, request exactly one packet per write, with no request after it.
- R6: Mode code 2 (automatic) requests a packet on the write itself and again on every cycle where status_in differs from its value one cycle earlier.
- R7: In automatic mode, a change that happens while data bytes are being sent raises pkt_rq in the cycle right after the last data byte; in modes 0, 1 and 3, a change of status raises no request.
- R8: A write with mode code 0 withdraws a request that has not yet been acknowledged, and later status changes raise none.
- R9: A pkt_start pulse while pkt_rq is low is ignored: no bytes are sent and pkt_ad stays 0x00.
- R10: The synchronous reset returns the block to the reset state of R1 at the next clock edge.
- R11: pkt_rq is low in every cycle in which a data byte is on pkt_ad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst | input | 1 | Asynchronous reset, active high |
| srst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control write strobe |
| cfg_wd | input | 8 | Control write data: [7:2] sequence, [1:0] mode |
| status_in | input | 26 | Status word to report |
| pkt_start | input | 1 | Acknowledge: address byte taken this cycle |
| pkt_rq | output | 1 | Packet request |
| pkt_ad | output | 8 | Packet byte (address, then data) |

## Verification
The assertions assume that pkt_start is a single-cycle pulse that the upstream side only gives while pkt_rq is high. A start pulse given at any other time must simply be ignored. They also assume that status_in and the control inputs change only between clock edges. The directed bench keeps to this: it drives every input on the falling edge, and it acknowledges only after it has seen the request. The one exception is a deliberate stray pulse, which tests that such a pulse is ignored. Status changes during a packet are placed on the first data byte, so that the capture rule and the deferred automatic request are both exercised.

// File: rtl/stat_pkt_pkg.sv
package stat_pkt_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    RPT_OFF   = 2'd0,
    RPT_ONCE  = 2'd1,
    RPT_AUTO  = 2'd2,
    RPT_ONCE3 = 2'd3
  } rpt_mode_e;
endpackage

// File: rtl/stat_pkt_chg.sv
module stat_pkt_chg #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         arst,
  input  logic         srst,
  input  logic [W-1:0] word_in,
  output logic         changed
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)      prev_q <= '0;
    else if (srst) prev_q <= '0;
    else           prev_q <= word_in;
  end

  assign changed = (word_in != prev_q);
endmodule

// File: rtl/stat_pkt_ctrl.sv
module stat_pkt_ctrl
  import stat_pkt_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int LOW_BITS = 2,
  localparam int SEQ_W   = BYTE_W - LOW_BITS
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              srst,
  input  logic              cfg_we,
  input  logic [BYTE_W-1:0] cfg_wd,
  input  logic              changed,
  input  logic              accept,
  output logic [SEQ_W-1:0]  seq,
  output logic              pending
);
  rpt_mode_e mode_q;
  rpt_mode_e wr_mode;

  assign wr_mode = rpt_mode_e'(cfg_wd[MODE_W-1:0]);

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      mode_q  <= RPT_OFF;
      seq     <= '0;
      pending <= 1'b0;
    end else if (srst) begin
      mode_q  <= RPT_OFF;
      seq     <= '0;
      pending <= 1'b0;
    end else begin
      if (cfg_we) begin
        mode_q  <= wr_mode;
        seq     <= cfg_wd[BYTE_W-1:LOW_BITS];
        pending <= (wr_mode != RPT_OFF);
      end else if (accept) begin
        pending <= 1'b0;
      end else if (mode_q == RPT_AUTO && changed) begin
        pending <= 1'b1;
      end
    end
  end

  // Request persists until taken or overridden by a write
  assert_req_held_R2: assert property (@(posedge clk) disable iff (arst || srst)
    pending && !accept && !cfg_we |=> pending);

  // Off mode drops the request
  assert_off_drops_R8: assert property (@(posedge clk) disable iff (arst || srst)
    cfg_we && cfg_wd[MODE_W-1:0] == 2'd0 |=> !pending);

  // Single mode: nothing new after the packet is taken
  assert_once_only_R5: assert property (@(posedge clk) disable iff (arst || srst)
    (mode_q == RPT_ONCE || mode_q == RPT_ONCE3) && !pending && !cfg_we |=> !pending);
endmodule

// File: rtl/stat_pkt_tx.sv
module stat_pkt_tx #(
  parameter int PAYLOAD_W   = 26,
  parameter int BYTE_W      = 8,
  parameter int LOW_BITS    = 2,
  parameter logic [7:0] ADDR = 8'h21,
  localparam int SEQ_W      = BYTE_W - LOW_BITS,
  localparam int SLICES     = (PAYLOAD_W - LOW_BITS + BYTE_W - 1) / BYTE_W,
  localparam int DATA_BYTES = SLICES + 1,
  localparam int SL_W       = SLICES * BYTE_W,
  localparam int CNT_W      = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic                 clk,
  input  logic                 arst,
  input  logic                 srst,
  input  logic                 pending,
  input  logic [SEQ_W-1:0]     seq,
  input  logic [PAYLOAD_W-1:0] status_in,
  input  logic                 start,
  output logic                 rq,
  output logic                 accept,
  output logic                 busy,
  output logic [BYTE_W-1:0]    ad
);
  logic [PAYLOAD_W-1:0] hold_q;
  logic [SEQ_W-1:0]     seq_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 last;
  logic [SL_W-1:0]      upper;
  logic [BYTE_W-1:0]    data_b [DATA_BYTES];

  assign rq     = pending && !busy;
  assign accept = rq && start;
  assign last   = (cnt_q == CNT_W'(DATA_BYTES - 1));
  assign upper  = SL_W'(hold_q[PAYLOAD_W-1:LOW_BITS]);

  assign data_b[0] = {seq_q, hold_q[LOW_BITS-1:0]};

  generate
    for (genvar g = 0; g < SLICES; g++) begin : g_slice
      assign data_b[g+1] = upper[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      hold_q <= '0;
      seq_q  <= '0;
      cnt_q  <= '0;
      busy   <= 1'b0;
    end else if (srst) begin
      hold_q <= '0;
      seq_q  <= '0;
      cnt_q  <= '0;
      busy   <= 1'b0;
    end else if (accept) begin
      hold_q <= status_in;
      seq_q  <= seq;
      cnt_q  <= '0;
      busy   <= 1'b1;
    end else if (busy) begin
      if (last) busy  <= 1'b0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (busy)    ad = data_b[cnt_q];
    else if (rq) ad = BYTE_W'(ADDR);
    else         ad = '0;
  end

  // Data bytes start only after an accepted address byte
  assert_burst_after_ack_R3: assert property (@(posedge clk) disable iff (arst || srst)
    $rose(busy) |-> $past(accept));

  // Captured word frozen for the whole packet
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (arst || srst)
    busy && !last |=> $stable(hold_q) && $stable(seq_q));

  // Request drops once taken
  assert_rq_drop_R11: assert property (@(posedge clk) disable iff (arst || srst)
    accept |=> !rq);
endmodule

// File: rtl/stat_pkt_ser.sv
module stat_pkt_ser #(
  parameter int PAYLOAD_W     = 26,
  parameter logic [7:0] ADDR  = 8'h21,
  localparam int BYTE_W       = 8,
  localparam int LOW_BITS     = 2
) (
  input  logic                 clk,
  input  logic                 arst,
  input  logic                 srst,
  input  logic                 cfg_we,
  input  logic [BYTE_W-1:0]    cfg_wd,
  input  logic [PAYLOAD_W-1:0] status_in,
  input  logic                 pkt_start,
  output logic                 pkt_rq,
  output logic [BYTE_W-1:0]    pkt_ad
);
  localparam int SEQ_W = BYTE_W - LOW_BITS;

  logic             changed;
  logic             accept;
  logic             busy;
  logic             pending;
  logic [SEQ_W-1:0] seq;

  stat_pkt_chg #(.W(PAYLOAD_W)) u_chg (
    .clk     (clk),
    .arst    (arst),
    .srst    (srst),
    .word_in (status_in),
    .changed (changed)
  );

  stat_pkt_ctrl #(.BYTE_W(BYTE_W), .LOW_BITS(LOW_BITS)) u_ctrl (
    .clk     (clk),
    .arst    (arst),
    .srst    (srst),
    .cfg_we  (cfg_we),
    .cfg_wd  (cfg_wd),
    .changed (changed),
    .accept  (accept),
    .seq     (seq),
    .pending (pending)
  );

  stat_pkt_tx #(
    .PAYLOAD_W (PAYLOAD_W),
    .BYTE_W    (BYTE_W),
    .LOW_BITS  (LOW_BITS),
    .ADDR      (ADDR)
  ) u_tx (
    .clk       (clk),
    .arst      (arst),
    .srst      (srst),
    .pending   (pending),
    .seq       (seq),
    .status_in (status_in),
    .start     (pkt_start),
    .rq        (pkt_rq),
    .accept    (accept),
    .busy      (busy),
    .ad        (pkt_ad)
  );

  // Address shown whenever a request is up
  assert_addr_on_rq_R2: assert property (@(posedge clk) disable iff (arst || srst)
    pkt_rq |-> pkt_ad == ADDR);

  // Stray start has no effect
  assert_stray_start_R9: assert property (@(posedge clk) disable iff (arst || srst)
    !pkt_rq && !busy && !cfg_we |=> !busy);

  // Synchronous reset clears the outputs
  assert_srst_clear_R10: assert property (@(posedge clk) disable iff (arst)
    srst |=> !pkt_rq && pkt_ad == '0);
endmodule

// File: tb/stat_pkt_ser_tb.sv
module stat_pkt_ser_tb;
  logic        clk = 1'b0;
  logic        arst = 1'b1;
  logic        srst = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wd = 8'h00;
  logic [25:0] status_in = 26'h0;
  logic        pkt_start = 1'b0;
  logic        pkt_rq;
  logic [7:0]  pkt_ad;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stat_pkt_ser u_dut (
    .clk       (clk),
    .arst      (arst),
    .srst      (srst),
    .cfg_we    (cfg_we),
    .cfg_wd    (cfg_wd),
    .status_in (status_in),
    .pkt_start (pkt_start),
    .pkt_rq    (pkt_rq),
    .pkt_ad    (pkt_ad)
  );

  function automatic logic [7:0] exp_byte(input logic [25:0] st, input logic [5:0] sq, input int i);
    case (i)
      1:       return {sq, st[1:0]};
      2:       return st[9:2];
      3:       return st[17:10];
      default: return st[25:18];
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] wd);
    cfg_we = 1'b1;
    cfg_wd = wd;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Takes one packet; optional status change on the first data byte
  task automatic recv(input logic [25:0] st, input logic [5:0] sq, input bit chg,
                      input logic [25:0] st_new, input string req);
    chk("R2", "rq before ack", 32'(pkt_rq), 32'd1);
    chk("R2", "address byte", 32'(pkt_ad), 32'h21);
    pkt_start = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (i == 1) begin
        pkt_start = 1'b0;
        if (chg) status_in = st_new;
      end
      chk(req, $sformatf("data byte %0d", i), 32'(pkt_ad), 32'(exp_byte(st, sq, i)));
      chk("R11", "rq during data", 32'(pkt_rq), 32'd0);
    end
  endtask

  task automatic t_reset;
    chk("R1", "rq in reset", 32'(pkt_rq), 32'd0);
    chk("R1", "ad in reset", 32'(pkt_ad), 32'd0);
    @(negedge clk);
    arst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "rq after reset", 32'(pkt_rq), 32'd0);
    chk("R1", "ad after reset", 32'(pkt_ad), 32'd0);
  endtask

  task automatic t_single;
    status_in = 26'h2A5C3F1;
    @(negedge clk);
    wr(8'hA9);
    chk("R5", "rq after single write", 32'(pkt_rq), 32'd1);
    repeat (3) begin
      @(negedge clk);
      chk("R2", "rq held", 32'(pkt_rq), 32'd1);
    end
    recv(26'h2A5C3F1, 6'h2A, 1'b0, 26'h0, "R3");
    @(negedge clk);
    chk("R3", "ad idle after packet", 32'(pkt_ad), 32'd0);
    chk("R5", "no second request", 32'(pkt_rq), 32'd0);
    status_in = 26'h1111111;
    @(negedge clk);
    chk("R7", "single mode ignores change", 32'(pkt_rq), 32'd0);
  endtask

  task automatic t_consistency;
    wr(8'h47);
    chk("R5", "reserved code requests", 32'(pkt_rq), 32'd1);
    recv(26'h1111111, 6'h11, 1'b1, 26'h3E0F0AB, "R4");
    @(negedge clk);
    chk("R5", "reserved code once only", 32'(pkt_rq), 32'd0);
    chk("R7", "reserved mode ignores change", 32'(pkt_rq), 32'd0);
  endtask

  task automatic t_auto;
    wr(8'h16);
    chk("R6", "auto write requests", 32'(pkt_rq), 32'd1);
    recv(26'h3E0F0AB, 6'h05, 1'b0, 26'h0, "R3");
    @(negedge clk);
    chk("R6", "stable status no rq", 32'(pkt_rq), 32'd0);
    status_in = 26'h0C0FFEE;
    @(negedge clk);
    chk("R6", "change raises rq", 32'(pkt_rq), 32'd1);
    recv(26'h0C0FFEE, 6'h05, 1'b1, 26'h2BADCAF, "R6");
    @(negedge clk);
    chk("R7", "deferred rq after packet", 32'(pkt_rq), 32'd1);
    recv(26'h2BADCAF, 6'h05, 1'b0, 26'h0, "R7");
    @(negedge clk);
    chk("R6", "no rq without change", 32'(pkt_rq), 32'd0);
  endtask

  task automatic t_off;
    status_in = 26'h0000155;
    @(negedge clk);
    chk("R6", "pending before off", 32'(pkt_rq), 32'd1);
    wr(8'h00);
    chk("R8", "off withdraws rq", 32'(pkt_rq), 32'd0);
    chk("R8", "off ad idle", 32'(pkt_ad), 32'd0);
    status_in = 26'h0000AAA;
    @(negedge clk);
    chk("R8", "off ignores change", 32'(pkt_rq), 32'd0);
  endtask

  task automatic t_stray;
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    chk("R9", "stray start ad", 32'(pkt_ad), 32'd0);
    @(negedge clk);
    chk("R9", "stray start ad later", 32'(pkt_ad), 32'd0);
    chk("R9", "stray start rq", 32'(pkt_rq), 32'd0);
  endtask

  task automatic t_srst;
    wr(8'h05);
    chk("R10", "rq before srst", 32'(pkt_rq), 32'd1);
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    chk("R10", "rq after srst", 32'(pkt_rq), 32'd0);
    chk("R10", "ad after srst", 32'(pkt_ad), 32'd0);
    status_in = 26'h3FFFFFF;
    @(negedge clk);
    chk("R10", "mode off after srst", 32'(pkt_rq), 32'd0);
    wr(8'h06);
    recv(26'h3FFFFFF, 6'h01, 1'b0, 26'h0, "R6");
    @(negedge clk);
    chk("R3", "ad idle at end", 32'(pkt_ad), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_consistency();
    t_auto();
    t_off();
    t_stray();
    t_srst();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule